// File: doc/BRIEF.md
# Receive Byte Queue with Trigger Threshold

This block buffers bytes arriving from a serial receiver until the host reads them. In queue mode it holds up to sixteen bytes in arrival order and reports the fill level, a not-empty (data ready) flag, a full flag and a trigger signal. The trigger signal is high once the level passes one of four programmable thresholds, so an interrupt controller can wait for a useful batch of bytes. An overrun flag records every byte that had to be thrown away. With queue mode switched off, the block acts as a single holding register: a new byte replaces the unread one and raises overrun.

Bytes come in over a valid/ready stream. `in_ready` is low only when the queue is full in queue mode and no pop happens in the same cycle. The receiver cannot stall, so a beat offered while `in_ready` is low is dropped and counted as an overrun, not held. Host reads are single-cycle strobes (`rd_en` with `rd_addr`). The read data is valid in the same cycle, and a read at a data address pops the head. The data address is 0x00, and sixteen alias addresses from 0x30 upward in steps of 4 (0x30, 0x34, ..., 0x6C) act the same way. `flush` empties the queue and serves both the control-register flush bit and the software receive reset. DEPTH must be a power of two.

Top module: `rxq_trigger_fifo`

## Requirements
- R1: After reset the level is 0, `not_empty`, `full` and `overrun` are 0, and `in_ready` is 1.
- R2: In queue mode bytes leave in arrival order. The level equals pushes minus pops. `full` is 1 when the level is 16. `not_empty` is 1 when the level is not 0, and it clears when the last byte is read.
- R3: In queue mode `in_ready` is 0 when the queue is full and no pop is made in the same cycle. A beat offered then is dropped, the stored bytes and the level stay unchanged, and `overrun` is set. A push made together with a pop on a full queue is accepted.
- R4: A push and a pop in the same cycle leave the level unchanged.
- R5: A data read on an empty queue returns 0 and changes no state.
- R6: `trig_sel` picks the threshold: 0 selects 0, 1 selects 4, 2 selects 8 and 3 selects 14. In queue mode `trig_hit` is 1 exactly when the level is strictly greater than the threshold.
- R7: `trig_hit` is 1 whenever queue mode is off (`fifo_en`=0), even when the block is empty.
- R8: With queue mode off the level is at most 1. A byte arriving while data is held, with no pop in that cycle, replaces the held byte and sets `overrun`.
- R9: Reads at 0x00 and at 0x30+4k for k=0..15 pop the head. A read at any other address returns 0 and pops nothing.
- R10: `flush` empties the block in the next cycle. A byte offered in the same cycle is discarded without setting `overrun`.
- R11: A change of `fifo_en` empties the block in the next cycle.
- R12: `overrun` stays set until `ovr_clr`. When a new overrun and `ovr_clr` occur in the same cycle, `overrun` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = sixteen-entry queue mode, 0 = single holding register |
| trig_sel | input | 2 | Trigger threshold code |
| flush | input | 1 | Empty the block |
| in_valid | input | 1 | Receiver byte valid |
| in_ready | output | 1 | Block can accept the offered byte |
| in_data | input | 8 | Receiver byte |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 8 | Host read byte address |
| rd_data | output | 8 | Head byte on a data read, else 0 |
| ovr_clr | input | 1 | Clear the overrun flag |
| level | output | 5 | Number of stored bytes |
| not_empty | output | 1 | Data ready: level is not 0 |
| full | output | 1 | Level is 16 |
| overrun | output | 1 | Sticky overrun flag |
| trig_hit | output | 1 | Level is above the threshold, or queue mode is off |

## Verification
The bench builds the block with its default parameters: sixteen entries, 8-bit data, an 8-bit read address and sixteen alias slots. With sixteen entries the thresholds 4, 8 and 14 lie only a few pushes away. That lets the bench walk each trigger code across its strict-greater boundary, fill the queue to exactly full for the drop and push-with-pop cases, and reach every alias address within one fill-and-drain pass.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    TRIG_ANY     = 2'd0,
    TRIG_QUARTER = 2'd1,
    TRIG_HALF    = 2'd2,
    TRIG_NEAR    = 2'd3
  } trig_e;

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          single,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rptr, wptr;
  logic [AW-1:0] wr_addr;
  logic          wr_en;

  // single mode always writes the slot at the head
  assign wr_addr = single ? rptr : wptr;
  assign wr_en   = push && !flush;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else if (flush) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else if (single) begin
      if (push) begin
        wptr  <= rptr + AW'(1);
        count <= CW'(1);
      end else if (pop) begin
        rptr  <= rptr + AW'(1);
        count <= '0;
      end
    end else begin
      if (push) wptr <= wptr + AW'(1);
      if (pop)  rptr <= rptr + AW'(1);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R8
  single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    single && !flush |=> count <= CW'(1));

endmodule

// File: rtl/rxq_thresh.sv
module rxq_thresh #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  rxq_pkg::trig_e code,
  input  logic           fifo_mode,
  input  logic [CW-1:0]  count,
  output logic           hit
);

  localparam logic [CW-1:0] THR_QUARTER = CW'(DEPTH / 4);
  localparam logic [CW-1:0] THR_HALF    = CW'(DEPTH / 2);
  localparam logic [CW-1:0] THR_NEAR    = CW'(DEPTH - 2);

  logic [CW-1:0] thr;

  always_comb begin
    unique case (code)
      rxq_pkg::TRIG_ANY:     thr = '0;
      rxq_pkg::TRIG_QUARTER: thr = THR_QUARTER;
      rxq_pkg::TRIG_HALF:    thr = THR_HALF;
      default:               thr = THR_NEAR;
    endcase
  end

  assign hit = !fifo_mode || (count > thr);

endmodule

// File: rtl/rxq_rdsel.sv
module rxq_rdsel #(
  parameter int ADDR_W     = 8,
  parameter int MAIN_OFF   = 'h00,
  parameter int ALIAS_BASE = 'h30,
  parameter int ALIAS_CNT  = 16,
  parameter int STRIDE     = 4
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              data_hit
);

  logic [ALIAS_CNT-1:0] match;

  for (genvar k = 0; k < ALIAS_CNT; k++) begin : g_alias
    assign match[k] = (rd_addr == ADDR_W'(ALIAS_BASE + k * STRIDE));
  end

  assign data_hit = rd_en && ((rd_addr == ADDR_W'(MAIN_OFF)) || (|match));

endmodule

// File: rtl/rxq_trigger_fifo.sv
module rxq_trigger_fifo #(
  parameter int DEPTH     = 16,
  parameter int W         = 8,
  parameter int ADDR_W    = 8,
  parameter int ALIAS_CNT = 16,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic [1:0]        trig_sel,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [W-1:0]      in_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  input  logic              ovr_clr,
  output logic [CW-1:0]     level,
  output logic              not_empty,
  output logic              full,
  output logic              overrun,
  output logic              trig_hit
);

  logic          mode_q;
  logic          mode_chg;
  logic          clear_all;
  logic          data_hit;
  logic          pop;
  logic          push;
  logic          drop;
  logic          overwrite;
  logic [W-1:0]  head;
  logic [CW-1:0] count;

  // a mode switch discards whatever the old mode held
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_en;
  end

  assign mode_chg  = (mode_q != fifo_en);
  assign clear_all = flush || mode_chg;

  assign not_empty = (count != '0);
  assign full      = (count == CW'(DEPTH));
  assign level     = count;

  rxq_rdsel #(
    .ADDR_W    (ADDR_W),
    .MAIN_OFF  ('h00),
    .ALIAS_BASE('h30),
    .ALIAS_CNT (ALIAS_CNT),
    .STRIDE    (4)
  ) u_rdsel (
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .data_hit(data_hit)
  );

  assign pop      = data_hit && not_empty;
  assign rd_data  = pop ? head : '0;

  assign in_ready  = !fifo_en || !full || pop;
  assign push      = in_valid && in_ready && !clear_all;
  assign drop      = fifo_en && in_valid && !in_ready && !clear_all;
  assign overwrite = !fifo_en && in_valid && not_empty && !pop && !clear_all;

  rxq_store #(
    .DEPTH(DEPTH),
    .W    (W)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (clear_all),
    .single (!fifo_en),
    .push   (push),
    .pop    (pop && !clear_all),
    .wr_data(in_data),
    .head   (head),
    .count  (count)
  );

  rxq_thresh #(
    .DEPTH(DEPTH)
  ) u_thresh (
    .code     (rxq_pkg::trig_e'(trig_sel)),
    .fifo_mode(fifo_en),
    .count    (count),
    .hit      (trig_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 overrun <= 1'b0;
    else if (drop || overwrite) overrun <= 1'b1;
    else if (ovr_clr)           overrun <= 1'b0;
  end

  // R3
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && in_valid && !in_ready && !clear_all |=> (level == $past(level)) && overrun);

  // R4
  pushpop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && in_valid && in_ready && rd_en && not_empty && data_hit && !clear_all
    |=> level == $past(level));

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !not_empty |-> rd_data == '0);

  // R7
  single_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> trig_hit);

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> level == '0);

  // R12
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clr |=> overrun);

endmodule

// File: tb/test_rxq_trigger_fifo.sv
module test_rxq_trigger_fifo;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b1;
  logic [1:0] trig_sel = 2'd0;
  logic       flush = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;
  logic       ovr_clr = 1'b0;
  logic [4:0] level;
  logic       not_empty, full, overrun, trig_hit;

  int checks = 0;
  int errors = 0;
  logic [7:0] got;
  logic       rdy;

  always #2 clk = ~clk;

  rxq_trigger_fifo i_rxq_trigger_fifo (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .flush(flush), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ovr_clr(ovr_clr),
    .level(level), .not_empty(not_empty), .full(full), .overrun(overrun),
    .trig_hit(trig_hit)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one cycle: drive, sample combinational outputs, clock, release
  task automatic op(input bit pv, input logic [7:0] pd, input bit re, input logic [7:0] ra);
    in_valid = pv; in_data = pd; rd_en = re; rd_addr = ra;
    #1;
    got = rd_data;
    rdy = in_ready;
    @(posedge clk); #1;
    in_valid = 1'b0; rd_en = 1'b0; flush = 1'b0; ovr_clr = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);  op(1'b1, d, 1'b0, 8'h00); endtask
  task automatic pop(input logic [7:0] a);   op(1'b0, 8'h00, 1'b1, a); endtask
  task automatic idle();                     op(1'b0, 8'h00, 1'b0, 8'h00); endtask
  task automatic empty_it();                 flush = 1'b1; idle(); endtask

  task automatic t_reset();
    check("R1 level", level, 0);
    check("R1 not_empty", not_empty, 0);
    check("R1 full", full, 0);
    check("R1 overrun", overrun, 0);
    check("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_order();
    for (int i = 0; i < 16; i++) push(8'(i * 7 + 3));
    check("R2 level full", level, 16);
    check("R2 full flag", full, 1);
    check("R2 not_empty", not_empty, 1);
    for (int i = 0; i < 16; i++) begin
      pop((i == 0) ? 8'h00 : 8'(8'h30 + (i - 1) * 4));
      check("R9 R2 order", got, 8'(i * 7 + 3));
    end
    check("R2 drained level", level, 0);
    check("R2 not_empty cleared", not_empty, 0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 16; i++) push(8'(8'h40 + i));
    push(8'hEE);
    check("R3 ready low when full", rdy, 0);
    check("R3 level kept", level, 16);
    check("R3 overrun set", overrun, 1);
    idle();
    check("R12 overrun sticky", overrun, 1);
    ovr_clr = 1'b1; push(8'hEF);
    check("R12 set wins over clear", overrun, 1);
    ovr_clr = 1'b1; idle();
    check("R12 cleared", overrun, 0);
    op(1'b1, 8'h99, 1'b1, 8'h00);
    check("R3 push with pop accepted", rdy, 1);
    check("R3 pop data", got, 8'h40);
    check("R4 level unchanged full", level, 16);
    for (int i = 1; i < 16; i++) begin
      pop(8'h00);
      check("R3 contents kept", got, 8'(8'h40 + i));
    end
    pop(8'h00);
    check("R3 last is accepted byte", got, 8'h99);
  endtask

  task automatic t_pushpop();
    push(8'h11); push(8'h22); push(8'h33);
    op(1'b1, 8'h44, 1'b1, 8'h3C);
    check("R4 pop data", got, 8'h11);
    check("R4 level", level, 3);
    empty_it();
  endtask

  task automatic t_empty_read();
    pop(8'h00);
    check("R5 empty read data", got, 0);
    check("R5 level", level, 0);
    check("R5 overrun", overrun, 0);
    push(8'h5A);
    pop(8'h04);
    check("R9 non-data addr data", got, 0);
    pop(8'h70);
    check("R9 past alias range", got, 0);
    pop(8'h32);
    check("R9 unaligned alias", got, 0);
    check("R9 level kept", level, 1);
    pop(8'h6C);
    check("R9 last alias pops", got, 8'h5A);
    check("R9 level after", level, 0);
  endtask

  task automatic t_trigger();
    for (int c = 0; c < 4; c++) begin
      int thr;
      thr = (c == 0) ? 0 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
      trig_sel = 2'(c);
      for (int n = 0; n < thr; n++) push(8'(n));
      #1;
      check($sformatf("R6 code %0d at threshold", c), trig_hit, 0);
      push(8'hA5);
      check($sformatf("R6 code %0d above threshold", c), trig_hit, 1);
      empty_it();
    end
    trig_sel = 2'd0;
  endtask

  task automatic t_single();
    fifo_en = 1'b0;
    idle();
    check("R7 trig when empty", trig_hit, 1);
    push(8'hA1);
    check("R8 level one", level, 1);
    check("R8 no overrun", overrun, 0);
    push(8'hB2);
    check("R8 level capped", level, 1);
    check("R8 overrun on overwrite", overrun, 1);
    pop(8'h00);
    check("R8 newest byte kept", got, 8'hB2);
    pop(8'h00);
    check("R8 empty read", got, 0);
    ovr_clr = 1'b1; idle();
    fifo_en = 1'b1;
    idle();
  endtask

  task automatic t_flush();
    for (int i = 0; i < 5; i++) push(8'(i));
    flush = 1'b1; push(8'h77);
    check("R10 level after flush", level, 0);
    check("R10 not_empty", not_empty, 0);
    check("R10 no overrun", overrun, 0);
    push(8'h01); push(8'h02); push(8'h03);
    fifo_en = 1'b0;
    idle();
    check("R11 mode change empties", level, 0);
    fifo_en = 1'b1;
    idle();
    push(8'hC3);
    pop(8'h00);
    check("R11 fresh data after switch", got, 8'hC3);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    #10;
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(); idle();
    t_reset();
    t_order();
    t_overflow();
    t_pushpop();
    t_empty_read();
    t_trigger();
    t_single();
    t_flush();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule